// File: doc/BRIEF.md
# Timekeeper Register Bank with Burst Snapshot

This block is the storage and policy stage behind a byte-oriented serial slave of a real-time clock. The slave decodes each byte transfer into a request carrying a direction, a target space (clock or RAM), a burst flag and an address. In a burst the address is the byte's position within the burst. The bank holds a control register with a write-protect bit, a trickle-charge configuration register and a 31-byte scratch RAM. The seven time registers live in an external calendar counter. The bank reads that counter's values from a live input and sends it load strobes whenever software writes time.

Three rules set it apart from a plain register file. A clock burst write is staged and reaches the counter, all seven bytes at once, only when the eighth byte arrives after a complete run of beats. RAM writes land byte by byte in either mode. A clock burst read takes a copy of the live time on its first beat and serves the later beats from that copy, so a running second counter cannot tear a multi-byte read. Every access answers on the cycle after its request.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, `ld_mask` is 0, `rd_valid` is 0, the control register reads 0x80 (write-protect set), the charge register reads 0x00 and `trickle_en` is 0.
- R2: With write-protect clear, a single (non-burst) write to clock address k (0..6) drives `ld_mask` to a one-hot value with only bit k set, and `ld_data[8k+7:8k]` to the written byte, on the cycle after the request. A single read of clock address k returns byte k of `live_time`.
- R3: The control register is clock address 7 and its write-protect bit is bit 7. Bits 6:0 always read 0. A single write to address 7 is always accepted. While write-protect is set, writes to time, RAM and the charge register change nothing.
- R4: A clock burst write stages beats 0..7. Beat 0 restarts the staging. The seven time bytes and the control byte commit only on beat 7, and only if beats 0..6 have all arrived since the last beat 0. The commit gives `ld_mask` = 0x7F with all staged bytes on `ld_data` for one cycle. No other beat drives a load.
- R5: If write-protect is set when beat 7 of a clock burst write arrives, nothing commits: no load strobe and no change to the control register.
- R6: RAM addresses 0..30 hold one byte each. A write in single or burst mode stores its byte at once, however many bytes the burst carries.
- R7: A clock burst read captures all seven live time bytes on beat 0 and returns live byte 0. Beats 1..6 return the captured bytes even if `live_time` has since changed. Beat 7 returns the control register.
- R8: Locations with no storage read 0x00 and ignore writes. These are clock addresses 9..31 in single mode, clock beats 8..31 in burst mode, and RAM address 31.
- R9: The charge register sits at clock address 8, single mode only. It reads back exactly as written. `diode_sel` is bits 3:2 and `res_sel` is bits 1:0. `trickle_en` is 1 only when bits 7:4 are 1010, `diode_sel` is 01 or 10, and `res_sel` is not 00.
- R10: `rd_valid` is high for exactly one cycle, on the cycle after each read request, and never after a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A byte request is present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ram | input | 1 | 1 = RAM space, 0 = clock space |
| req_burst | input | 1 | Request is a beat of a burst; `req_addr` is the beat index |
| req_addr | input | 5 | Register address or beat index |
| req_wdata | input | 8 | Write byte |
| live_time | input | 56 | Calendar counter values, byte k = time register k |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| ld_mask | output | 7 | Per-register load strobe to the calendar counter |
| ld_data | output | 56 | Load values, byte k for time register k |
| trickle_en | output | 1 | Decoded charger enable |
| diode_sel | output | 2 | Diode select field of the charge register |
| res_sel | output | 2 | Resistor select field of the charge register |

## Verification
The bound checker checks the per-cycle rules on every edge. A single time write must give the matching one-hot load. With write-protect set, no write loads anything and a burst leaves protection on. Beats other than 7 never load. Writes to holes never load. The charger enable agrees with its fields. `rd_valid` follows read requests exactly. Some behaviours need sequences and memory, so only the bench scenarios show them: an interrupted burst that must not commit, the frozen snapshot while `live_time` moves, RAM and charge register contents read back after blocked or accepted writes, and the reset values.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 5;
    localparam int TIME_REGS    = 7;
    localparam int CLK_BEATS    = 8;
    localparam int RAM_WORDS    = 31;
    localparam int CTRL_ADDR    = 7;
    localparam int CHARGE_ADDR  = 8;
    localparam logic [7:0] CTRL_RESET   = 8'h80;
    localparam logic [7:0] CHARGE_RESET = 8'h00;
    localparam logic [3:0] CHARGE_KEY   = 4'b1010;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        TGT_TIME,
        TGT_CTRL,
        TGT_CHARGE,
        TGT_RAM,
        TGT_HOLE
    } target_e;

    function automatic target_e decode_target(input logic ram, input logic burst,
                                              input logic [ADDR_W-1:0] addr,
                                              input int ram_words, input int time_regs);
        if (ram)
            return (int'(addr) < ram_words) ? TGT_RAM : TGT_HOLE;
        if (int'(addr) < time_regs)
            return TGT_TIME;
        if (int'(addr) == CTRL_ADDR)
            return TGT_CTRL;
        if (int'(addr) == CHARGE_ADDR && !burst)
            return TGT_CHARGE;
        return TGT_HOLE;
    endfunction

    function automatic logic charge_enabled(input byte_t cfg);
        return (cfg[7:4] == CHARGE_KEY) &&
               (cfg[3:2] == 2'b01 || cfg[3:2] == 2'b10) &&
               (cfg[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
    parameter int WORDS  = 31,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && int'(waddr) == i)
                mem[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++)
            if (int'(raddr) == i)
                rdata = mem[i];
    end
endmodule

// File: rtl/rtc_burst_stager.sv
module rtc_burst_stager #(
    parameter int BEATS = 8,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   beat,
    input  logic [IDX_W-1:0]       idx,
    input  logic [7:0]             wdata,
    output logic                   last_complete,
    output logic [BEATS-2:0][7:0]  staged
);
    logic [BEATS-2:0] seen_q;

    assign last_complete = beat && (int'(idx) == BEATS - 1) && (&seen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            staged <= '0;
        end else if (beat) begin
            if (int'(idx) == BEATS - 1) begin
                seen_q <= '0;
            end else begin
                for (int i = 0; i < BEATS - 1; i++) begin
                    if (int'(idx) == i) begin
                        staged[i] <= wdata;
                        if (i == 0)
                            seen_q <= (BEATS-1)'(1);
                        else
                            seen_q[i] <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_time_snapshot.sv
module rtc_time_snapshot #(
    parameter int REGS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [REGS*8-1:0]   live,
    output logic [REGS*8-1:0]   snap
);
    always_ff @(posedge clk) begin
        if (rst)
            snap <= '0;
        else if (capture)
            snap <= live;
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int NUM_TIME  = TIME_REGS,
    parameter int NUM_RAM   = RAM_WORDS,
    localparam int TIME_W   = NUM_TIME * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic              req_ram,
    input  logic              req_burst,
    input  logic [4:0]        req_addr,
    input  logic [7:0]        req_wdata,
    input  logic [TIME_W-1:0] live_time,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [NUM_TIME-1:0] ld_mask,
    output logic [TIME_W-1:0] ld_data,
    output logic              trickle_en,
    output logic [1:0]        diode_sel,
    output logic [1:0]        res_sel
);
    target_e tgt;
    logic    wp_q;
    byte_t   charge_q;
    logic    do_wr, do_rd;
    logic    ram_we;
    byte_t   ram_rdata;
    logic    beat, commit, capture;
    logic [NUM_TIME-1:0][7:0] staged;
    logic [TIME_W-1:0] snap;
    byte_t   live_byte, snap_byte, rd_next;

    assign tgt     = decode_target(req_ram, req_burst, req_addr, NUM_RAM, NUM_TIME);
    assign do_wr   = req_valid && req_wr;
    assign do_rd   = req_valid && !req_wr;
    assign ram_we  = do_wr && tgt == TGT_RAM && !wp_q;
    assign beat    = do_wr && !req_ram && req_burst && req_addr[4:3] == 2'b00;
    assign capture = do_rd && !req_ram && req_burst && req_addr == '0;

    rtc_scratch_ram #(.WORDS(NUM_RAM), .ADDR_W(5)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(req_addr), .wdata(req_wdata),
        .raddr(req_addr), .rdata(ram_rdata)
    );

    rtc_burst_stager #(.BEATS(NUM_TIME + 1)) u_stage (
        .clk(clk), .rst(rst), .beat(beat), .idx(req_addr[2:0]), .wdata(req_wdata),
        .last_complete(commit), .staged(staged)
    );

    rtc_time_snapshot #(.REGS(NUM_TIME)) u_snap (
        .clk(clk), .rst(rst), .capture(capture), .live(live_time), .snap(snap)
    );

    assign live_byte = byte_t'(live_time >> {req_addr[2:0], 3'b000});
    assign snap_byte = byte_t'(snap >> {req_addr[2:0], 3'b000});

    always_comb begin
        unique case (tgt)
            TGT_TIME:   rd_next = (req_burst && req_addr != '0) ? snap_byte : live_byte;
            TGT_CTRL:   rd_next = {wp_q, 7'b0};
            TGT_CHARGE: rd_next = charge_q;
            TGT_RAM:    rd_next = ram_rdata;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= CTRL_RESET[7];
            charge_q <= CHARGE_RESET;
            ld_mask  <= '0;
            ld_data  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            ld_mask  <= '0;
            rd_valid <= do_rd;
            if (do_rd)
                rd_data <= rd_next;
            if (do_wr && !req_burst && tgt == TGT_CTRL)
                wp_q <= req_wdata[7];
            if (do_wr && tgt == TGT_CHARGE && !wp_q)
                charge_q <= req_wdata;
            if (do_wr && !req_burst && tgt == TGT_TIME && !wp_q) begin
                for (int i = 0; i < NUM_TIME; i++) begin
                    if (int'(req_addr) == i) begin
                        ld_mask[i]         <= 1'b1;
                        ld_data[i*8 +: 8]  <= req_wdata;
                    end
                end
            end
            if (commit && !wp_q) begin
                ld_mask <= '1;
                ld_data <= staged;
                wp_q    <= req_wdata[7];
            end
        end
    end

    assign trickle_en = charge_enabled(charge_q);
    assign diode_sel  = charge_q[3:2];
    assign res_sel    = charge_q[1:0];
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_wr,
    input logic        req_ram,
    input logic        req_burst,
    input logic [4:0]  req_addr,
    input logic [7:0]  req_wdata,
    input logic        rd_valid,
    input logic [6:0]  ld_mask,
    input logic [55:0] ld_data,
    input logic        trickle_en,
    input logic [1:0]  diode_sel,
    input logic [1:0]  res_sel,
    input logic        wp
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (ld_mask == '0 && !rd_valid));

    a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && !req_ram && !req_burst && req_addr < 5'd7 && !wp)
        |=> (ld_mask == (7'b1 << $past(req_addr[2:0])) &&
             8'(ld_data >> {$past(req_addr[2:0]), 3'b000}) == $past(req_wdata)));

    a_r3_protect_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && wp) |=> (ld_mask == '0));

    a_r4_no_early_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && !req_ram && req_burst && req_addr != 5'd7)
        |=> (ld_mask == '0));

    a_r5_burst_keeps_wp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && !req_ram && req_burst && wp) |=> wp);

    a_r8_hole_no_load: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && !req_ram &&
         (req_addr > 5'd8 || (req_burst && req_addr == 5'd8)))
        |=> (ld_mask == '0));

    a_r9_enable_fields: assert property (@(posedge clk) disable iff (rst)
        trickle_en |-> ((diode_sel == 2'b01 || diode_sel == 2'b10) && res_sel != 2'b00));

    a_r10_read_valid: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wr) |=> rd_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_wr) |=> !rd_valid);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr), .req_ram(req_ram),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .ld_mask(ld_mask), .ld_data(ld_data),
    .trickle_en(trickle_en), .diode_sel(diode_sel), .res_sel(res_sel), .wp(wp_q)
);

// File: tb/rtc_regfile_bench.sv
`timescale 1ns/1ps
module rtc_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_wr = 1'b0, req_ram = 1'b0, req_burst = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [55:0] live_time = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [6:0]  ld_mask;
    logic [55:0] ld_data;
    logic        trickle_en;
    logic [1:0]  diode_sel, res_sel;

    int tests = 0;
    int fails = 0;

    typedef struct { logic [7:0] d; string tag; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    rtc_regfile u_rtc_regfile (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wr(req_wr), .req_ram(req_ram),
        .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
        .live_time(live_time), .rd_valid(rd_valid), .rd_data(rd_data),
        .ld_mask(ld_mask), .ld_data(ld_data), .trickle_en(trickle_en),
        .diode_sel(diode_sel), .res_sel(res_sel)
    );

    task automatic check(input longint act, input longint exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input bit ram, input bit burst,
                         input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_ram = ram; req_burst = burst;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    task automatic rd(input bit ram, input bit burst, input logic [4:0] a,
                      input logic [7:0] exp, input string tag);
        exp_t e;
        e.d = exp; e.tag = tag;
        sb.push_back(e);
        issue(1'b0, ram, burst, a, 8'h00);
    endtask

    task automatic wr(input bit ram, input bit burst, input logic [4:0] a,
                      input logic [7:0] d);
        issue(1'b1, ram, burst, a, d);
        check(rd_valid, 0, "R10 no read strobe on write");
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb.size() == 0) begin
                tests++; fails++;
                $display("FAIL R10: unexpected rd_valid, actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rd_data, e.d, e.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  bb [8];
        logic [55:0] snap_l, snap_m;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        check(ld_mask, 0, "R1 ld_mask");
        check(rd_valid, 0, "R1 rd_valid");
        check(trickle_en, 0, "R1 trickle_en");
        rd(0, 0, 5'd7, 8'h80, "R1 control reset");
        rd(0, 0, 5'd8, 8'h00, "R1 charge reset");

        // R3 write-protect blocks time, RAM, charge
        wr(0, 0, 5'd2, 8'h33);
        check(ld_mask, 0, "R3 protected time write");
        wr(1, 0, 5'd3, 8'h5C);
        rd(1, 0, 5'd3, 8'h00, "R3 protected RAM write");
        wr(0, 0, 5'd8, 8'hA5);
        rd(0, 0, 5'd8, 8'h00, "R3 protected charge write");
        check(trickle_en, 0, "R3 charge stays off");

        // R3 control low bits, write always accepted
        wr(0, 0, 5'd7, 8'hFF);
        rd(0, 0, 5'd7, 8'h80, "R3 control low bits zero");
        wr(0, 0, 5'd7, 8'h00);
        rd(0, 0, 5'd7, 8'h00, "R3 control cleared");

        // R2 single time write and read
        wr(0, 0, 5'd4, 8'h12);
        check(ld_mask, 7'h10, "R2 one-hot mask");
        check(ld_data[39:32], 8'h12, "R2 load byte");
        wr(0, 0, 5'd0, 8'h59);
        check(ld_mask, 7'h01, "R2 one-hot mask addr0");
        live_time = 56'h24_06_09_15_23_47_08;
        rd(0, 0, 5'd1, 8'h47, "R2 live read addr1");
        rd(0, 0, 5'd6, 8'h24, "R2 live read addr6");

        // R6 RAM single and short burst
        wr(1, 0, 5'd0, 8'hA5);
        wr(1, 0, 5'd30, 8'h5A);
        wr(1, 1, 5'd0, 8'h11);
        wr(1, 1, 5'd1, 8'h22);
        wr(1, 1, 5'd2, 8'h33);
        rd(1, 0, 5'd30, 8'h5A, "R6 RAM addr30");
        rd(1, 0, 5'd0, 8'h11, "R6 burst byte0 overwrote");
        rd(1, 1, 5'd1, 8'h22, "R6 burst byte1");
        rd(1, 0, 5'd2, 8'h33, "R6 burst byte2");

        // R8 holes
        wr(1, 0, 5'd31, 8'hFF);
        rd(1, 0, 5'd31, 8'h00, "R8 RAM addr31");
        wr(0, 0, 5'd9, 8'h77);
        check(ld_mask, 0, "R8 clock hole write");
        rd(0, 0, 5'd12, 8'h00, "R8 clock hole read");
        rd(0, 1, 5'd8, 8'h00, "R8 burst beat8 read");

        // R9 charge register decode
        wr(0, 0, 5'd8, 8'hA5);
        check(trickle_en, 1, "R9 enable 1010/01/01");
        check(diode_sel, 2'b01, "R9 diode field");
        check(res_sel, 2'b01, "R9 resistor field");
        rd(0, 0, 5'd8, 8'hA5, "R9 readback");
        wr(0, 0, 5'd8, 8'hAD);
        check(trickle_en, 0, "R9 diode 11 disables");
        wr(0, 0, 5'd8, 8'hA4);
        check(trickle_en, 0, "R9 resistor 00 disables");
        wr(0, 0, 5'd8, 8'hB9);
        check(trickle_en, 0, "R9 wrong key disables");
        rd(0, 0, 5'd8, 8'hB9, "R9 readback disabled value");
        wr(0, 0, 5'd8, 8'hAA);
        check(trickle_en, 1, "R9 enable 1010/10/10");
        wr(0, 1, 5'd8, 8'h00);
        rd(0, 0, 5'd8, 8'hAA, "R9 not reachable in burst");

        // R4 partial burst then beat 7 must not commit
        for (int k = 0; k < 5; k++) begin
            wr(0, 1, 5'(k), 8'h99);
            check(ld_mask, 0, "R4 partial beat no load");
        end
        wr(0, 1, 5'd7, 8'h00);
        check(ld_mask, 0, "R4 incomplete burst no commit");

        // R4 complete burst commits
        bb = '{8'h30, 8'h45, 8'h12, 8'h07, 8'h11, 8'h03, 8'h24, 8'h00};
        for (int k = 0; k < 8; k++) begin
            wr(0, 1, 5'(k), bb[k]);
            if (k < 7) check(ld_mask, 0, "R4 beat before last no load");
        end
        check(ld_mask, 7'h7F, "R4 commit mask");
        check(ld_data, 56'h24_03_11_07_12_45_30, "R4 commit data");
        rd(0, 0, 5'd7, 8'h00, "R4 control from burst");

        // R5 protected burst commits nothing
        wr(0, 0, 5'd7, 8'h80);
        for (int k = 0; k < 8; k++) wr(0, 1, 5'(k), (k == 7) ? 8'h00 : 8'h55);
        check(ld_mask, 0, "R5 protected burst no load");
        rd(0, 0, 5'd7, 8'h80, "R5 control unchanged");

        // R7 snapshot during burst read
        snap_l = 56'h25_01_31_12_23_59_58;
        snap_m = 56'h26_02_01_01_00_00_00;
        live_time = snap_l;
        rd(0, 1, 5'd0, snap_l[7:0], "R7 beat0 live");
        live_time = snap_m;
        for (int k = 1; k < 7; k++)
            rd(0, 1, 5'(k), 8'(snap_l >> (8 * k)), "R7 frozen beat");
        rd(0, 1, 5'd7, 8'h80, "R7 beat7 control");
        rd(0, 0, 5'd1, snap_m[15:8], "R7 single read sees live");

        repeat (3) @(negedge clk);
        check(sb.size(), 0, "R10 every read answered");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule